// File: doc/BRIEF.md
# Endpoint FIFO Bus Port with Longword Prefetch

This block sits between a processor-side request/acknowledge bus and a set of endpoint data FIFOs. Each endpoint is reached through one data location chosen by the endpoint number on the bus. A request names the endpoint, the access size (byte, word or longword) and the direction. The block answers with a one-cycle acknowledge. Writes push one entry into the selected FIFO and reads pop one entry from it.

The acknowledge comes after a wait that depends on several things: the access size, the number of idle clocks since the previous access finished, and whether a longword read finds a valid prefetched copy of the FIFO head. After every longword read, the block loads the next head of that endpoint into a single shared holding register, provided the FIFO is not empty. A later longword read to the same endpoint is then served from that register and finishes sooner. The holding register is dropped by any access to a different endpoint and by any byte or word access. A run of longword writes to the same endpoint also gets gap-dependent timing.

The controller has three states. `ST_IDLE` waits for a request, and its *accept* transition latches the request and loads the wait counter. `ST_WAIT` counts down, and its *expire* transition fires when the counter reaches zero. `ST_DONE` drives the acknowledge, the push or pop and the read data for exactly one cycle, then takes the *release* transition back to `ST_IDLE`. Cycle 1 of an access is the idle cycle in which the request is first seen, and the acknowledge is high in cycle L, where L is the latency listed below.

Top module: `epfifo_port`

## Requirements
- R1: With bus_size 0 (byte), a read acknowledges in cycle 5 and a write acknowledges in cycle 4.
- R2: With bus_size 1 (word), a read acknowledges in cycle 6 and a write acknowledges in cycle 4.
- R3: A longword read (bus_size 2 or 3) with no valid prefetch for its endpoint acknowledges in cycle 8. This includes the first longword read after reset.
- R4: A longword read that hits the prefetch, when the access just before it was a longword read that missed, acknowledges in cycle 4 if there was no idle gap and in cycle 3 for any gap of one or more clocks.
- R5: Any other prefetch hit acknowledges in cycle 6, 5, 4 or 3 for an idle gap of 0, 1, 2 or 3 clocks. A gap above 3 counts as 3.
- R6: A longword write acknowledges in cycle 4 unless the previous access was a longword write to the same endpoint. In that case it acknowledges in cycle 6, 5 or 4 for a gap of 0, 1, or 2 or more clocks.
- R7: An access to a different endpoint, or any byte or word access, drops the prefetch, so the next longword read costs 8 cycles. A longword write to the same endpoint keeps the prefetch.
- R8: The prefetch is not loaded when the endpoint FIFO is empty after the pop of a longword read, so the next longword read to it costs 8 cycles even if data arrived in between.
- R9: Every read pops exactly one entry of the addressed FIFO (fifo_pop bit = endpoint number) in its acknowledge cycle, never pops an empty FIFO, and returns the entries in FIFO order on bus_rdata.
- R10: Every write raises exactly the addressed fifo_push bit in its acknowledge cycle, with the request's write data and size on fifo_push_data and fifo_push_size.
- R11: After reset and whenever no access is finishing, bus_ack, fifo_push and fifo_pop are low. The acknowledge lasts one cycle, and the idle gap after reset counts as 3 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| bus_ep | input | EPW | Endpoint selected |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion |
| fifo_push | output | N_EP | Push strobe per endpoint |
| fifo_push_data | output | DW | Data pushed |
| fifo_push_size | output | 2 | Size of the pushed entry |
| fifo_pop | output | N_EP | Pop strobe per endpoint |
| fifo_pop_size | output | 2 | Size of the read consuming the entry |
| fifo_head | input | N_EP*DW | Head entry of each FIFO, first-word-fall-through |
| fifo_empty | input | N_EP | Empty flag per endpoint |

## Verification
Two functions can land in the same cycle. One is the prefetch load that follows a longword read. The other is the acceptance of the next request, which happens when the master issues it with no idle clock. The bench provokes this with back-to-back longword reads to the same endpoint, which must count as hits. It also issues an immediate access to another endpoint or a byte access, where the drop must win over the load. A gap-zero longword write to an endpoint that has just been emptied checks that the pending load neither fires on an empty FIFO nor survives until the next read. Every case is judged on the acknowledge cycle number, the returned data order and the push and pop strobes.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } fsm_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    localparam int LAT_W = 4;
    localparam int GAP_W = 2;

    function automatic logic size_is_long(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/epp_gap.sv
module epp_gap #(
    parameter int GAP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] GMAX = {GAP_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= GMAX;
        end else if (clr) begin
            gap <= '0;
        end else if (inc && gap != GMAX) begin
            gap <= gap + 1'b1;
        end
    end
endmodule

// File: rtl/epp_lat.sv
module epp_lat #(
    parameter int LAT_W         = 4,
    parameter int GAP_W         = 2,
    parameter int RD_BYTE       = 5,
    parameter int RD_WORD       = 6,
    parameter int RD_MISS       = 8,
    parameter int RD_FOLLOW_B2B = 4,
    parameter int RD_STREAM_MAX = 6,
    parameter int RD_HIT_MIN    = 3,
    parameter int WR_SHORT      = 4,
    parameter int WR_CHAIN_MAX  = 6,
    parameter int WR_FLOOR      = 4
) (
    input  logic             we,
    input  logic [1:0]       size,
    input  logic [GAP_W-1:0] gap,
    input  logic             hit,
    input  logic             after_miss,
    input  logic             wr_chain,
    output logic [LAT_W-1:0] lat
);
    int stream_t;
    int chain_t;

    always_comb begin
        stream_t = RD_STREAM_MAX - int'(gap);
        chain_t  = WR_CHAIN_MAX - int'(gap);
        if (stream_t < RD_HIT_MIN) stream_t = RD_HIT_MIN;
        if (chain_t < WR_FLOOR)    chain_t  = WR_FLOOR;

        if (we) begin
            if (size[1] && wr_chain) lat = LAT_W'(chain_t);
            else                     lat = LAT_W'(WR_SHORT);
        end else if (!size[1]) begin
            lat = size[0] ? LAT_W'(RD_WORD) : LAT_W'(RD_BYTE);
        end else if (!hit) begin
            lat = LAT_W'(RD_MISS);
        end else if (after_miss) begin
            lat = (gap == '0) ? LAT_W'(RD_FOLLOW_B2B) : LAT_W'(RD_HIT_MIN);
        end else begin
            lat = LAT_W'(stream_t);
        end
    end
endmodule

// File: rtl/epp_pref.sv
module epp_pref #(
    parameter int N_EP = 4,
    parameter int DW   = 32,
    parameter int EPW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [EPW-1:0]   arm_ep,
    input  logic             cancel,
    input  logic             consume,
    input  logic [N_EP-1:0]  fifo_empty,
    input  logic [N_EP*DW-1:0] fifo_head,
    output logic             avail,
    output logic [EPW-1:0]   pf_ep,
    output logic [DW-1:0]    pf_data
);
    logic pending;
    logic valid;
    logic load;

    // A load happens one cycle after the arming read, only on a non-empty FIFO.
    assign load  = pending && !fifo_empty[pf_ep];
    assign avail = valid || load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            valid   <= 1'b0;
            pf_ep   <= '0;
            pf_data <= '0;
        end else begin
            pending <= arm;
            if (arm)  pf_ep   <= arm_ep;
            if (load) pf_data <= fifo_head[pf_ep*DW +: DW];
            if (cancel)       valid <= 1'b0;
            else if (load)    valid <= 1'b1;
            else if (consume) valid <= 1'b0;
        end
    end
endmodule

// File: rtl/epfifo_port.sv
module epfifo_port
    import epp_pkg::*;
#(
    parameter int N_EP = 4,
    parameter int DW   = 32,
    parameter int EPW  = (N_EP > 1) ? $clog2(N_EP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [1:0]         bus_size,
    input  logic [EPW-1:0]     bus_ep,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               bus_ack,
    output logic [N_EP-1:0]    fifo_push,
    output logic [DW-1:0]      fifo_push_data,
    output logic [1:0]         fifo_push_size,
    output logic [N_EP-1:0]    fifo_pop,
    output logic [1:0]         fifo_pop_size,
    input  logic [N_EP*DW-1:0] fifo_head,
    input  logic [N_EP-1:0]    fifo_empty
);
    localparam logic [LAT_W-1:0] LAT_BIAS = LAT_W'(3);

    fsm_e state, state_n;

    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] lat;
    logic [GAP_W-1:0] gap;
    logic [EPW-1:0]   ep_q, last_ep;
    logic             we_q, hit_q;
    logic [1:0]       size_q;
    logic [DW-1:0]    wdata_q;
    logic             after_miss, wr_chain;

    logic             accept, done;
    logic             avail, hit_req, cancel;
    logic [EPW-1:0]   pf_ep;
    logic [DW-1:0]    pf_data;
    logic [DW-1:0]    head_sel;

    assign accept   = (state == ST_IDLE) && bus_req;
    assign done     = (state == ST_DONE);
    assign hit_req  = !bus_we && size_is_long(bus_size) && avail && (pf_ep == bus_ep);
    assign cancel   = accept && !(size_is_long(bus_size) && (bus_ep == pf_ep));
    assign head_sel = fifo_head[ep_q*DW +: DW];

    epp_gap #(.GAP_W(GAP_W)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (done),
        .inc   ((state == ST_IDLE) && !bus_req),
        .gap   (gap)
    );

    epp_lat #(.LAT_W(LAT_W), .GAP_W(GAP_W)) u_lat (
        .we         (bus_we),
        .size       (bus_size),
        .gap        (gap),
        .hit        (hit_req),
        .after_miss (after_miss),
        .wr_chain   (wr_chain && (bus_ep == last_ep)),
        .lat        (lat)
    );

    epp_pref #(.N_EP(N_EP), .DW(DW), .EPW(EPW)) u_pref (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (done && !we_q && size_is_long(size_q)),
        .arm_ep     (ep_q),
        .cancel     (cancel),
        .consume    (done && hit_q),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .avail      (avail),
        .pf_ep      (pf_ep),
        .pf_data    (pf_data)
    );

    // Next state: accept, expire, release.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (bus_req)    state_n = ST_WAIT;
            ST_WAIT: if (cnt == '0)  state_n = ST_DONE;
            ST_DONE:                 state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Request latch, wait counter and streak history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            ep_q       <= '0;
            we_q       <= 1'b0;
            size_q     <= SZ_BYTE;
            wdata_q    <= '0;
            hit_q      <= 1'b0;
            last_ep    <= '0;
            after_miss <= 1'b0;
            wr_chain   <= 1'b0;
        end else begin
            if (accept) begin
                cnt     <= lat - LAT_BIAS;
                ep_q    <= bus_ep;
                we_q    <= bus_we;
                size_q  <= bus_size;
                wdata_q <= bus_wdata;
                hit_q   <= hit_req;
            end else if (state == ST_WAIT && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (done) begin
                last_ep    <= ep_q;
                after_miss <= !we_q && size_is_long(size_q) && !hit_q;
                wr_chain   <= we_q && size_is_long(size_q);
            end
        end
    end

    // Outputs.
    always_comb begin
        bus_ack        = done;
        fifo_push      = '0;
        fifo_pop       = '0;
        fifo_push_data = wdata_q;
        fifo_push_size = size_q;
        fifo_pop_size  = size_q;
        bus_rdata      = '0;
        if (done) begin
            if (we_q) begin
                fifo_push[ep_q] = 1'b1;
            end else begin
                fifo_pop[ep_q] = !fifo_empty[ep_q];
                bus_rdata      = hit_q ? pf_data : head_sel;
            end
        end
    end
endmodule

// File: rtl/epp_checker.sv
module epp_checker #(
    parameter int N_EP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_req,
    input logic            bus_we,
    input logic [1:0]      bus_size,
    input logic            bus_ack,
    input logic [N_EP-1:0] fifo_push,
    input logic [N_EP-1:0] fifo_pop,
    input logic [N_EP-1:0] fifo_empty
);
    logic       busy_c;
    logic [3:0] cnt_c;
    logic       c_we;
    logic [1:0] c_size;

    // Independent cycle count of the access in flight (cycle 1 = request seen).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            cnt_c  <= '0;
            c_we   <= 1'b0;
            c_size <= '0;
        end else if (!busy_c && bus_req) begin
            busy_c <= 1'b1;
            cnt_c  <= 4'd2;
            c_we   <= bus_we;
            c_size <= bus_size;
        end else if (busy_c) begin
            if (bus_ack)              busy_c <= 1'b0;
            else if (cnt_c != 4'd15)  cnt_c  <= cnt_c + 4'd1;
        end
    end

    a_r1_byte_time: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && c_size == 2'd0) |-> (cnt_c == (c_we ? 4'd4 : 4'd5)));
    a_r2_word_time: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && c_size == 2'd1) |-> (cnt_c == (c_we ? 4'd4 : 4'd6)));
    a_r3_long_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && c_size[1] && !c_we) |-> (cnt_c >= 4'd3 && cnt_c <= 4'd8));
    a_r6_long_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && c_size[1] && c_we) |-> (cnt_c >= 4'd4 && cnt_c <= 4'd6));
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop & fifo_empty) == '0);
    a_r9_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));
    a_r9_pop_on_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_pop) |-> (bus_ack && !c_we));
    a_r10_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_push));
    a_r10_push_on_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_push) |-> (bus_ack && c_we));
    a_r11_ack_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> busy_c);
    a_r11_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
endmodule

bind epfifo_port epp_checker #(.N_EP(N_EP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_size   (bus_size),
    .bus_ack    (bus_ack),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty)
);

// File: tb/sim_epfifo_port.sv
module sim_epfifo_port;
    localparam int N_EP = 4;
    localparam int DW   = 32;
    localparam int EPW  = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_req = 1'b0;
    logic               bus_we = 1'b0;
    logic [1:0]         bus_size = 2'd0;
    logic [EPW-1:0]     bus_ep = '0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic               bus_ack;
    logic [N_EP-1:0]    fifo_push, fifo_pop;
    logic [DW-1:0]      fifo_push_data;
    logic [1:0]         fifo_push_size, fifo_pop_size;
    logic [N_EP*DW-1:0] fifo_head = '0;
    logic [N_EP-1:0]    fifo_empty = '1;

    always #10 clk = ~clk;

    epfifo_port #(.N_EP(N_EP), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_ep(bus_ep), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .fifo_push(fifo_push),
        .fifo_push_data(fifo_push_data), .fifo_push_size(fifo_push_size),
        .fifo_pop(fifo_pop), .fifo_pop_size(fifo_pop_size),
        .fifo_head(fifo_head), .fifo_empty(fifo_empty)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pop_bad = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // FIFO model behind the port.
    logic [DW-1:0] fq [N_EP][$];
    always @(posedge clk) begin
        for (int e = 0; e < N_EP; e++) begin
            if (fifo_push[e]) fq[e].push_back(fifo_push_data);
            if (fifo_pop[e]) begin
                if (fq[e].size() == 0) pop_bad++;
                else void'(fq[e].pop_front());
            end
            fifo_head[e*DW +: DW] <= (fq[e].size() != 0) ? fq[e][0] : '0;
            fifo_empty[e]         <= (fq[e].size() == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard.
    typedef struct {
        int            start;
        int            lat;
        bit            we;
        int            ep;
        logic [1:0]    size;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    // Reference model state.
    logic [DW-1:0] ref_q [N_EP][$];
    bit m_pfv = 0;
    int m_pfep = 0;
    bit m_miss = 0;
    bit m_lw = 0;
    int m_last_ep = 0;
    int wseq = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_ack) begin
                if (sbq.size() == 0) begin
                    check(0, "R11", "ack with nothing pending", 1, 0);
                end else begin
                    exp_t it;
                    it = sbq.pop_front();
                    check(cyc - it.start + 1 == it.lat, it.tag, "ack cycle",
                          cyc - it.start + 1, it.lat);
                    if (it.we) begin
                        check(fifo_push == N_EP'(1 << it.ep) && fifo_pop == '0, "R10",
                              "push strobe", fifo_push, 1 << it.ep);
                        check(fifo_push_data == it.data && fifo_push_size == it.size, "R10",
                              "push data", fifo_push_data, it.data);
                    end else begin
                        check(bus_rdata == it.data, "R9", "read data", bus_rdata, it.data);
                        check(fifo_pop == N_EP'(1 << it.ep) && fifo_push == '0, "R9",
                              "pop strobe", fifo_pop, 1 << it.ep);
                    end
                end
            end else if (fifo_pop != '0 || fifo_push != '0) begin
                check(0, "R11", "strobe outside ack", {fifo_pop, fifo_push}, 0);
            end
        end
    end

    function automatic int model_lat(input int ep, input bit we, input logic [1:0] sz,
                                     input int gap);
        bit hit;
        if (we) begin
            if (sz[1] && m_lw && ep == m_last_ep)
                return (gap == 0) ? 6 : (gap == 1) ? 5 : 4;   // R6
            return 4;                                          // R1 R2 R6
        end
        if (sz == 2'd0) return 5;                              // R1
        if (sz == 2'd1) return 6;                              // R2
        hit = m_pfv && (m_pfep == ep);
        if (!hit) return 8;                                    // R3
        if (m_miss) return (gap == 0) ? 4 : 3;                 // R4
        return 6 - gap;                                        // R5
    endfunction

    task automatic access(input int ep, input bit we, input logic [1:0] sz,
                          input int g, input string tag);
        exp_t it;
        int gap;
        bit hit;
        gap = (g > 3) ? 3 : g;
        it.lat  = model_lat(ep, we, sz, gap);
        it.we   = we;
        it.ep   = ep;
        it.size = sz;
        it.tag  = tag;
        hit = m_pfv && (m_pfep == ep);
        if (we) begin
            wseq++;
            it.data = 32'hC0DE_0000 + DW'(wseq);
            ref_q[ep].push_back(it.data);
        end else begin
            it.data = ref_q[ep].pop_front();
        end
        // Model update.
        if (!we && sz[1]) begin
            m_miss = !hit;
            m_pfv  = (ref_q[ep].size() != 0);
            m_pfep = ep;
        end else begin
            m_miss = 0;
            if (!(we && sz[1] && ep == m_pfep)) m_pfv = 0;
        end
        m_lw      = we && sz[1];
        m_last_ep = ep;

        bus_req = 1'b0;
        repeat (g + 1) @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_size  = sz;
        bus_ep    = EPW'(ep);
        bus_wdata = it.data;
        it.start  = cyc;
        sbq.push_back(it);
        do @(negedge clk); while (!bus_ack);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            fq[0].push_back(32'h1000_0000 + DW'(i));
            ref_q[0].push_back(32'h1000_0000 + DW'(i));
        end
        for (int i = 0; i < 3; i++) begin
            fq[1].push_back(32'h2000_0000 + DW'(i));
            ref_q[1].push_back(32'h2000_0000 + DW'(i));
        end
        fq[3].push_back(32'h4000_0000);
        ref_q[3].push_back(32'h4000_0000);

        repeat (4) @(negedge clk);
        check(bus_ack == 1'b0, "R11", "ack in reset", bus_ack, 0);
        check(fifo_pop == '0, "R11", "pop in reset", fifo_pop, 0);
        check(fifo_push == '0, "R11", "push in reset", fifo_push, 0);
        rst_n = 1'b1;

        access(0, 0, 2'd2, 3, "R3");   // first longword read: 8
        access(0, 0, 2'd2, 0, "R4");   // hit right after miss: 4
        access(0, 0, 2'd2, 0, "R5");   // 6
        access(0, 0, 2'd3, 0, "R5");   // size 3 as longword: 6
        access(0, 0, 2'd2, 1, "R5");   // 5
        access(0, 0, 2'd2, 2, "R5");   // 4
        access(0, 0, 2'd2, 3, "R5");   // 3
        access(0, 0, 2'd2, 7, "R5");   // gap saturates: 3
        access(1, 0, 2'd2, 0, "R7");   // endpoint switch: 8
        access(1, 0, 2'd2, 1, "R4");   // hit after miss with gap: 3
        access(0, 0, 2'd2, 0, "R7");   // switch back: 8
        access(0, 0, 2'd0, 0, "R1");   // byte read: 5
        access(0, 0, 2'd2, 0, "R7");   // byte dropped prefetch: 8
        access(0, 0, 2'd1, 1, "R2");   // word read: 6
        access(1, 1, 2'd0, 0, "R1");   // byte write: 4
        access(1, 1, 2'd1, 2, "R2");   // word write: 4
        access(2, 1, 2'd2, 0, "R6");   // 4
        access(2, 1, 2'd2, 0, "R6");   // 6
        access(2, 1, 2'd2, 1, "R6");   // 5
        access(2, 1, 2'd2, 2, "R6");   // 4
        access(2, 1, 2'd2, 0, "R6");   // 6
        access(3, 1, 2'd2, 0, "R6");   // other endpoint: 4
        access(2, 0, 2'd2, 1, "R3");   // 8
        access(2, 1, 2'd2, 0, "R7");   // same-endpoint write keeps prefetch
        access(2, 0, 2'd2, 0, "R5");   // still a hit: 6-0
        access(3, 0, 2'd2, 0, "R3");   // 8, leaves 1 entry
        access(3, 0, 2'd2, 0, "R4");   // hit: 4, FIFO now empty
        access(3, 1, 2'd2, 0, "R8");   // write during skipped load: 4
        access(3, 0, 2'd2, 0, "R8");   // no prefetch: 8
        access(1, 0, 2'd0, 2, "R9");   // byte read returns pushed order

        bus_req = 1'b0;
        repeat (5) @(negedge clk);
        check(sbq.size() == 0, "R11", "pending accesses", sbq.size(), 0);
        check(pop_bad == 0, "R9", "pops of empty FIFO", pop_bad, 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule